// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block is the transmit side of a master-mode serial audio port. It takes stereo sample words from a valid/ready stream and shifts them out MSB first on one data line. It also generates the bit clock and the frame-sync (word-select) clock itself. One framing engine covers four framings. A 2-bit format field chooses between PCM (short sync pulse), the justified family and right-justified. In the justified family, a one-bit data-delay flag selects I2S timing (delay 1) or left-justified timing (delay 0). A sync-period field sets the phase length in bit clocks, independent of the sample width. A normal setting is twice the word length minus one.

The bit clock is derived from a one-cycle enable pulse, `bclk_tick`. Each pulse is one half period of the bit clock. The configuration arrives as plain static inputs: format, delay, resolution and slot codes, sync period, the two clock polarities, the two clock drive enables, the channel mask and count, a global enable and a transmit enable. Words enter as left, then right. The block holds at most one queued stereo pair. `s_ready` stays high while fewer than two words are queued, and drops once a full pair is waiting. That back-pressure holds the source until the pair is taken at the next frame start. A transfer happens on any `clk` edge where both `s_valid` and `s_ready` are high.

Top module: `audio_tx_top`

## Requirements
- R1: In format 1 (justified), the frame-sync pin (non-inverted) is low for the left phase and high for the right. Each phase sends its word MSB first, starting `data_delay` bit clocks after the phase begins. A delay of 1 gives I2S timing and 0 gives left-justified timing. Bits after the word's LSB are zero.
- R2: In format 2 (right-justified), the word's LSB falls on the last bit clock of its phase, and the leading bit clocks are zero. `data_delay` has no effect in this format.
- R3: In format 0 (PCM), frame sync is high for exactly the first bit clock of each frame. The left word starts `data_delay` bit clocks into the frame. The right word starts one slot width after the left word's start.
- R4: A phase spans `sync_period`+1 bit clocks, and a frame spans two phases in every format.
- R5: The resolution and slot codes are 3 = 16, 4 = 20 and 5 = 24 bits. The configuration is rejected, and `cfg_err` is high, under any of these conditions: another code is used, the slot is narrower than the resolution, the format is 3, `chan_count_m1` is not 1, or `chan_mask` is not 8'h03. While rejected, the block stays idle even with `global_en` set.
- R6: `bclk_invert` and `lrck_invert` independently invert the bit-clock and frame-sync pins.
- R7: `sdata_out` changes only on falling edges of the non-inverted bit clock. It is stable on every rising edge.
- R8: While `global_en` is low, the clocks stop, the pins rest at their idle levels (the polarity bit when driven), the data pin is zero and `underrun` is cleared.
- R9: With `tx_en` low, `sdata_out` stays zero while both clocks keep running.
- R10: When `bclk_drive` or `lrck_drive` is low, the matching pin is held at zero whatever the clocks do.
- R11: `s_ready` is high while fewer than two words are queued, and it drops after the second word is accepted. Words are taken as left, then right.
- R12: If a full pair is not queued at a frame start, that frame is sent as zeros and `underrun` sets. It then stays set until `global_en` goes low.
- R13: After reset, the clock and data pins are at their idle levels, `underrun` is low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_tick | input | 1 | Half-bit-clock enable pulse |
| global_en | input | 1 | Enables the whole block |
| tx_en | input | 1 | Enables the data line |
| fmt_mode | input | 2 | 0 PCM, 1 justified, 2 right-justified |
| data_delay | input | 1 | Data delay after sync edge, in bit clocks (0 or 1) |
| res_code | input | 3 | Sample resolution code |
| slot_code | input | 3 | Slot width code |
| sync_period | input | PER_W | Phase length minus one, in bit clocks |
| bclk_invert | input | 1 | Invert bit-clock pin |
| lrck_invert | input | 1 | Invert frame-sync pin |
| bclk_drive | input | 1 | Drive bit-clock pin |
| lrck_drive | input | 1 | Drive frame-sync pin |
| chan_mask | input | MASK_W | Active channel mask, must be 8'h03 |
| chan_count_m1 | input | 3 | Channel count minus one, must be 1 |
| s_valid | input | 1 | Sample word valid |
| s_data | input | SAMPLE_W | Sample word, right-aligned |
| s_ready | output | 1 | Block can accept a word |
| bclk_out | output | 1 | Bit-clock pin |
| lrck_out | output | 1 | Frame-sync pin |
| sdata_out | output | 1 | Serial data pin |
| cfg_err | output | 1 | Configuration rejected |
| underrun | output | 1 | Sticky missed-frame flag |

## Verification
The bench captures whole frames at the receiver's sampling edge. It compares them bit by bit against a model of each framing, across all resolutions and both polarities. This exposes an off-by-one in the delay, a right-justified word shifted away from the phase end, or a PCM right word at the wrong slot. Directed cases starve the stream to check that zero frames and the sticky flag appear, and that the flag clears only on disable. They also fill the queue without enabling, to show back-pressure. Further cases turn off the data line and each clock drive, where a design that ignores those bits would leak activity onto a pin. Each rejected-configuration case must keep the bit clock dead, which a lax code check would not.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef enum logic [1:0] {
    FMT_PCM   = 2'd0,
    FMT_JUST  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_e;

  // Width code to bit count; zero marks an unsupported code.
  function automatic logic [4:0] code_bits(input logic [2:0] code);
    case (code)
      3'd3:    code_bits = 5'd16;
      3'd4:    code_bits = 5'd20;
      3'd5:    code_bits = 5'd24;
      default: code_bits = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/audio_tx_bitclk.sv
module audio_tx_bitclk (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic bclk_q,
  output logic start,
  output logic advance
);

  logic running;

  // The first tick only arms the frame; later ticks toggle the clock.
  assign start   = run && tick && !running;
  assign advance = run && tick && (!running || bclk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      bclk_q  <= 1'b0;
    end else if (!run) begin
      running <= 1'b0;
      bclk_q  <= 1'b0;
    end else if (tick) begin
      if (!running) running <= 1'b1;
      else          bclk_q  <= ~bclk_q;
    end
  end

endmodule

// File: rtl/audio_tx_feed.sv
module audio_tx_feed #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  input  logic                take,
  output logic [SAMPLE_W-1:0] pend_l,
  output logic [SAMPLE_W-1:0] pend_r,
  output logic                pend_ok,
  output logic [1:0]          pend_cnt
);

  logic accept;

  assign s_ready = (pend_cnt != 2'd2);
  assign pend_ok = (pend_cnt == 2'd2);
  assign accept  = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cnt <= 2'd0;
      pend_l   <= '0;
      pend_r   <= '0;
    end else if (take && pend_ok) begin
      pend_cnt <= 2'd0;
    end else if (accept) begin
      if (pend_cnt == 2'd0) pend_l <= s_data;
      else                  pend_r <= s_data;
      pend_cnt <= pend_cnt + 2'd1;
    end
  end

endmodule

// File: rtl/audio_tx_framer.sv
module audio_tx_framer
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int PER_W    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                advance,
  input  logic                start,
  input  logic [1:0]          mode,
  input  logic                delay,
  input  logic [4:0]          wbits,
  input  logic [4:0]          sbits,
  input  logic [PER_W-1:0]    period,
  input  logic [SAMPLE_W-1:0] pend_l,
  input  logic [SAMPLE_W-1:0] pend_r,
  input  logic                pend_ok,
  output logic                frame_start,
  output logic                sd_q,
  output logic                lr_q
);

  localparam int CNT_W = PER_W + 1;

  logic [CNT_W-1:0]    cnt, cnt_n, last;
  logic [SAMPLE_W-1:0] act_l, act_r, nxt_l, nxt_r, word;
  logic                sd_n, lr_n, hi, in_word;
  logic [4:0]          idx;
  int                  c, p, w, s, pos, k;

  assign last        = {period, 1'b1};
  assign frame_start = advance && (start || cnt == last);
  assign cnt_n       = (start || cnt == last) ? '0 : cnt + 1'b1;
  assign nxt_l       = frame_start ? (pend_ok ? pend_l : '0) : act_l;
  assign nxt_r       = frame_start ? (pend_ok ? pend_r : '0) : act_r;

  always_comb begin
    c       = int'(cnt_n);
    p       = int'(period) + 1;
    w       = int'(wbits);
    s       = int'(sbits);
    hi      = (c >= p);
    pos     = hi ? c - p : c;
    word    = hi ? nxt_r : nxt_l;
    lr_n    = hi;
    k       = 0;
    in_word = 1'b0;
    case (fmt_e'(mode))
      FMT_JUST: begin
        k       = pos - int'(delay);
        in_word = (k >= 0) && (k < w);
      end
      FMT_RIGHT: begin
        k       = pos - (p - w);
        in_word = (k >= 0) && (k < w);
      end
      FMT_PCM: begin
        lr_n = (c == 0);
        k    = c - int'(delay);
        if (k >= 0 && k < w) begin
          word    = nxt_l;
          in_word = 1'b1;
        end else if (k >= s && k < s + w) begin
          word    = nxt_r;
          k       = k - s;
          in_word = 1'b1;
        end
      end
      default: lr_n = 1'b0;
    endcase
    idx  = in_word ? 5'(w - 1 - k) : 5'd0;
    sd_n = in_word && word[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sd_q  <= 1'b0;
      lr_q  <= 1'b0;
      act_l <= '0;
      act_r <= '0;
    end else if (!run) begin
      cnt   <= '0;
      sd_q  <= 1'b0;
      lr_q  <= 1'b0;
      act_l <= '0;
      act_r <= '0;
    end else if (advance) begin
      cnt   <= cnt_n;
      sd_q  <= sd_n;
      lr_q  <= lr_n;
      act_l <= nxt_l;
      act_r <= nxt_r;
    end
  end

endmodule

// File: rtl/audio_tx_top.sv
module audio_tx_top
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int PER_W    = 10,
  parameter int MASK_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_tick,
  input  logic                global_en,
  input  logic                tx_en,
  input  logic [1:0]          fmt_mode,
  input  logic                data_delay,
  input  logic [2:0]          res_code,
  input  logic [2:0]          slot_code,
  input  logic [PER_W-1:0]    sync_period,
  input  logic                bclk_invert,
  input  logic                lrck_invert,
  input  logic                bclk_drive,
  input  logic                lrck_drive,
  input  logic [MASK_W-1:0]   chan_mask,
  input  logic [2:0]          chan_count_m1,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  output logic                bclk_out,
  output logic                lrck_out,
  output logic                sdata_out,
  output logic                cfg_err,
  output logic                underrun
);

  localparam int          STEREO    = 2;
  localparam logic [MASK_W-1:0] STEREO_MASK = MASK_W'((1 << STEREO) - 1);

  logic [4:0]          wbits, sbits;
  logic                run, bclk_q, start, advance, frame_start, sd_q, lr_q, pend_ok;
  logic [SAMPLE_W-1:0] pend_l, pend_r;
  logic [1:0]          pend_cnt;

  assign wbits   = code_bits(res_code);
  assign sbits   = code_bits(slot_code);
  assign cfg_err = (wbits == 5'd0) || (sbits == 5'd0) || (sbits < wbits) ||
                   (fmt_mode == FMT_RSVD) || (chan_count_m1 != 3'(STEREO - 1)) ||
                   (chan_mask != STEREO_MASK);
  assign run     = global_en && !cfg_err;

  audio_tx_bitclk u_bitclk (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(bclk_tick),
    .bclk_q(bclk_q), .start(start), .advance(advance)
  );

  audio_tx_feed #(.SAMPLE_W(SAMPLE_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .take(frame_start), .pend_l(pend_l),
    .pend_r(pend_r), .pend_ok(pend_ok), .pend_cnt(pend_cnt)
  );

  audio_tx_framer #(.SAMPLE_W(SAMPLE_W), .PER_W(PER_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .run(run), .advance(advance), .start(start),
    .mode(fmt_mode), .delay(data_delay), .wbits(wbits), .sbits(sbits),
    .period(sync_period), .pend_l(pend_l), .pend_r(pend_r), .pend_ok(pend_ok),
    .frame_start(frame_start), .sd_q(sd_q), .lr_q(lr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       underrun <= 1'b0;
    else if (!global_en)              underrun <= 1'b0;
    else if (frame_start && !pend_ok) underrun <= 1'b1;
  end

  assign bclk_out  = bclk_drive && (bclk_q ^ bclk_invert);
  assign lrck_out  = lrck_drive && (lr_q ^ lrck_invert);
  assign sdata_out = tx_en && sd_q;

endmodule

// File: rtl/audio_tx_checker.sv
module audio_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       global_en,
  input logic       bclk_invert,
  input logic       bclk_drive,
  input logic       lrck_invert,
  input logic       lrck_drive,
  input logic       s_valid,
  input logic       s_ready,
  input logic       bclk_out,
  input logic       lrck_out,
  input logic       sdata_out,
  input logic       cfg_err,
  input logic       underrun,
  input logic       frame_start,
  input logic [1:0] pend_cnt
);

  // R7: data never moves on the receiver's sampling edge
  a_r7_data_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!bclk_invert && $stable(bclk_invert) && bclk_drive && $rose(bclk_out))
      |-> $stable(sdata_out));

  // R12: underrun stays set while enabled
  a_r12_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && global_en) |=> underrun);

  // R5: rejected configuration keeps the bit clock at rest
  a_r5_idle_on_bad_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> (bclk_out == (bclk_drive && bclk_invert)));

  // R8: disabled block rests the frame-sync pin
  a_r8_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!global_en) |-> (lrck_out == (lrck_drive && lrck_invert)));

  // R11: second accepted word closes the queue
  a_r11_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && pend_cnt == 2'd1 && !frame_start) |=> !s_ready);

  // R11: queue never holds more than a pair
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt != 2'd3);

endmodule

bind audio_tx_top audio_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .global_en(global_en),
  .bclk_invert(bclk_invert), .bclk_drive(bclk_drive),
  .lrck_invert(lrck_invert), .lrck_drive(lrck_drive),
  .s_valid(s_valid), .s_ready(s_ready), .bclk_out(bclk_out),
  .lrck_out(lrck_out), .sdata_out(sdata_out), .cfg_err(cfg_err),
  .underrun(underrun), .frame_start(frame_start), .pend_cnt(pend_cnt)
);

// File: tb/audio_tx_top_test.sv
module audio_tx_top_test;

  typedef struct packed {
    logic [1:0]  mode;
    logic        dly;
    logic [2:0]  res;
    logic [2:0]  slot;
    logic [9:0]  per;
    logic        binv;
    logic        linv;
    logic [23:0] l;
    logic [23:0] r;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b1, 3'd3, 3'd3, 10'd19, 1'b0, 1'b0, 24'h00A5C3, 24'h005A3C},
    '{2'd1, 1'b0, 3'd5, 3'd5, 10'd25, 1'b0, 1'b0, 24'hC0FFEE, 24'h123456},
    '{2'd2, 1'b0, 3'd4, 3'd4, 10'd23, 1'b0, 1'b0, 24'h0ABCDE, 24'h054321},
    '{2'd0, 1'b1, 3'd3, 3'd3, 10'd19, 1'b0, 1'b0, 24'h00F00F, 24'h00813C},
    '{2'd0, 1'b0, 3'd3, 3'd4, 10'd19, 1'b0, 1'b0, 24'h00B00B, 24'h001234},
    '{2'd1, 1'b1, 3'd3, 3'd3, 10'd19, 1'b1, 1'b1, 24'h009999, 24'h006666},
    '{2'd2, 1'b1, 3'd3, 3'd5, 10'd17, 1'b0, 1'b1, 24'h00FACE, 24'h00BEEF}
  };

  logic        clk = 1'b0, rst_n = 1'b0, bclk_tick = 1'b1;
  logic        global_en = 1'b0, tx_en = 1'b1;
  logic [1:0]  fmt_mode = 2'd1;
  logic        data_delay = 1'b1;
  logic [2:0]  res_code = 3'd3, slot_code = 3'd3;
  logic [9:0]  sync_period = 10'd19;
  logic        bclk_invert = 1'b0, lrck_invert = 1'b0;
  logic        bclk_drive = 1'b1, lrck_drive = 1'b1;
  logic [7:0]  chan_mask = 8'h03;
  logic [2:0]  chan_count_m1 = 3'd1;
  logic        s_valid = 1'b0;
  logic [23:0] s_data = '0;
  logic        s_ready, bclk_out, lrck_out, sdata_out, cfg_err, underrun;

  int n_checks = 0, n_fail = 0;

  audio_tx_top uut (.*);

  always #10 clk = ~clk;

  // ---------------- stream feeder ----------------
  logic        feed_on = 1'b0;
  logic [23:0] feed_l = '0, feed_r = '0;
  logic        feed_ch = 1'b0, rdy_seen = 1'b0;
  int          n_acc = 0;
  initial forever begin
    @(negedge clk);
    if (!rst_n) begin
      feed_ch = 1'b0; n_acc = 0; rdy_seen = 1'b0; s_valid = 1'b0;
    end else begin
      if (s_valid && rdy_seen) begin feed_ch = ~feed_ch; n_acc++; end
      rdy_seen = s_ready;
      s_valid  = feed_on;
      s_data   = feed_ch ? feed_r : feed_l;
    end
  end

  // ---------------- pin monitor ----------------
  logic mon_clr = 1'b0;
  logic cap_d [256];
  logic cap_l [256];
  int   bitn = 0, b_chg = 0, l_chg = 0, d_ones = 0, b_high = 0, l_high = 0;
  logic prev_b = 1'b0, prev_l = 1'b0;
  initial forever begin
    @(negedge clk);
    if (mon_clr) begin
      bitn = 0; b_chg = 0; l_chg = 0; d_ones = 0; b_high = 0; l_high = 0;
    end else begin
      if (bclk_out != prev_b) b_chg++;
      if (lrck_out != prev_l) l_chg++;
      if (sdata_out) d_ones++;
      if (bclk_out) b_high++;
      if (lrck_out) l_high++;
      if ((bclk_invert ? (prev_b && !bclk_out) : (!prev_b && bclk_out)) && bitn < 256) begin
        cap_d[bitn] = sdata_out;
        cap_l[bitn] = lrck_out;
        bitn++;
      end
    end
    prev_b = bclk_out;
    prev_l = lrck_out;
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic do_reset();
    global_en = 1'b0;
    feed_on   = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic clear_mon();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    fmt_mode = v.mode; data_delay = v.dly; res_code = v.res; slot_code = v.slot;
    sync_period = v.per; bclk_invert = v.binv; lrck_invert = v.linv;
    feed_l = v.l; feed_r = v.r;
  endtask

  function automatic int bits_of(input logic [2:0] code);
    return (code == 3'd3) ? 16 : (code == 3'd4) ? 20 : 24;
  endfunction

  // Expected data bit at bit clock c of a frame, from R1, R2, R3.
  function automatic logic exp_data(input vec_t v, input int c);
    int p = int'(v.per) + 1, w = bits_of(v.res), s = bits_of(v.slot);
    int ph = (c >= p) ? 1 : 0;
    int pos = c - ph * p, k;
    logic [23:0] wd = ph ? v.r : v.l;
    if (v.mode == 2'd1) begin
      k = pos - int'(v.dly);
      return (k >= 0 && k < w) ? wd[w-1-k] : 1'b0;
    end else if (v.mode == 2'd2) begin
      k = pos - (p - w);
      return (k >= 0) ? wd[w-1-k] : 1'b0;
    end
    k = c - int'(v.dly);
    if (k >= 0 && k < w) return v.l[w-1-k];
    if (k >= s && k < s + w) return v.r[w-1-(k-s)];
    return 1'b0;
  endfunction

  function automatic logic exp_sync(input vec_t v, input int c);
    int p = int'(v.per) + 1;
    logic raw = (v.mode == 2'd0) ? (c == 0) : (c >= p);
    return raw ^ v.linv;
  endfunction

  task automatic wait_bits(input int n);
    for (int t = 0; t < 4000 && bitn < n; t++) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20ns * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  // ---------------- main sequence ----------------
  initial begin
    do_reset();

    // R13: reset state
    check("R13", "s_ready", int'(s_ready), 1);
    check("R13", "bclk_out", int'(bclk_out), 0);
    check("R13", "lrck_out", int'(lrck_out), 0);
    check("R13", "sdata_out", int'(sdata_out), 0);
    check("R13", "underrun", int'(underrun), 0);

    // Table walk: R1 R2 R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      int p2 = 2 * (int'(v.per) + 1);
      int bad_d = -1, bad_l = -1;
      apply(v);
      do_reset();
      feed_on = 1'b1;
      repeat (8) @(negedge clk);
      clear_mon();
      @(negedge clk); global_en = 1'b1;
      wait_bits(2 * p2);
      for (int b = 2 * p2 - 1; b >= 0; b--) begin
        if (cap_d[b] != exp_data(v, b % p2)) bad_d = b;
        if (cap_l[b] != exp_sync(v, b % p2)) bad_l = b;
      end
      check(v.mode == 2'd2 ? "R2" : v.mode == 2'd0 ? "R3" : "R1",
            $sformatf("vec %0d first bad data bit", i), bad_d, -1);
      check("R4", $sformatf("vec %0d first bad sync bit (R6 pol)", i), bad_l, -1);
      check("R12", $sformatf("vec %0d underrun", i), int'(underrun), 0);
    end

    // R11: back-pressure while disabled
    apply(VECS[0]);
    do_reset();
    feed_on = 1'b1;
    repeat (10) @(negedge clk);
    check("R11", "s_ready with pair queued", int'(s_ready), 0);
    check("R11", "words accepted", n_acc, 2);

    // R12: starved frame is zero and sets sticky flag
    do_reset();
    clear_mon();
    @(negedge clk); global_en = 1'b1;
    wait_bits(45);
    check("R12", "underrun after starved frame", int'(underrun), 1);
    check("R12", "data ones in starved frames", d_ones, 0);
    feed_on = 1'b1;
    repeat (200) @(negedge clk);
    check("R12", "underrun stays set", int'(underrun), 1);
    // R8: disabling clears flag and rests pins
    global_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "underrun after disable", int'(underrun), 0);
    check("R8", "bclk idle", int'(bclk_out), 0);
    check("R8", "lrck idle", int'(lrck_out), 0);

    // R9: data line off, clocks run
    do_reset();
    feed_on = 1'b1; tx_en = 1'b0;
    repeat (8) @(negedge clk);
    clear_mon();
    @(negedge clk); global_en = 1'b1;
    repeat (200) @(negedge clk);
    check("R9", "data ones with tx off", d_ones, 0);
    check("R9", "bclk running", int'(b_chg > 20), 1);
    check("R9", "lrck running", int'(l_chg > 2), 1);
    tx_en = 1'b1;

    // R10: each clock drive off
    do_reset();
    feed_on = 1'b1; bclk_drive = 1'b0;
    repeat (8) @(negedge clk);
    clear_mon();
    @(negedge clk); global_en = 1'b1;
    repeat (200) @(negedge clk);
    check("R10", "bclk high count, drive off", b_high, 0);
    check("R10", "lrck running with bclk off", int'(l_chg > 2), 1);
    bclk_drive = 1'b1; lrck_drive = 1'b0;
    clear_mon();
    repeat (200) @(negedge clk);
    check("R10", "lrck high count, drive off", l_high, 0);
    check("R10", "bclk running with lrck off", int'(b_chg > 20), 1);
    lrck_drive = 1'b1;

    // R5: rejected configurations
    for (int j = 0; j < 4; j++) begin
      apply(VECS[0]);
      do_reset();
      case (j)
        0: res_code = 3'd6;
        1: fmt_mode = 2'd3;
        2: chan_mask = 8'h01;
        default: begin res_code = 3'd5; slot_code = 3'd3; end
      endcase
      @(negedge clk);
      check("R5", $sformatf("cfg_err case %0d", j), int'(cfg_err), 1);
      clear_mon();
      @(negedge clk); global_en = 1'b1;
      repeat (60) @(negedge clk);
      check("R5", $sformatf("bclk toggles case %0d", j), b_chg, 0);
      chan_mask = 8'h03;
    end

    finish_run();
  end

endmodule